// File: doc/BRIEF.md
# Serial Monitor Mode Entry Sequencer

This block decides, once per reset, whether the chip enters a serial debug monitor. In the first clock after the internal reset is released it looks at a high-voltage detect flag from the interrupt pin and at a two-bit mode-select input. It keeps that decision until the next reset. Later changes on those inputs do not alter it.

Once in monitor mode, the block listens on a shared single-wire line for security bytes from the host. Each byte is a UART frame, and the receiver oversamples it with a 16x bit-rate tick. Good bytes are shown on an output register with a one-clock valid pulse, and a saturating counter tracks how many have arrived. When the eighth good byte has been taken, the block drives the line low for ten bit times as a break. It then raises a ready flag that stays high until the next reset. Comparing the bytes with a stored key and executing commands are left to other logic.

A clock-source select output moves to the internal oscillator once the interrupt pin has dropped back to normal level after entry. It never moves back during the session.

Top module: `mon_entry_seq`

## Requirements
- R1: `monMode` becomes 1 in the first clock after `rstN` rises if, at that edge, `hvDetect` is 1 and `modeSel` equals 2'b01. Otherwise it becomes 0. It is 0 while reset is held.
- R2: After that first clock, `monMode` keeps its value until the next reset, whatever `hvDetect` and `modeSel` do.
- R3: A received frame is one low start bit, 8 data bits sent LSB first, and one stop bit. Each bit lasts 16 `bitTick16` ticks and is sampled near its middle. A frame whose stop bit is 1 is a good byte: it is loaded into `rxByte` and `rxValid` pulses for one clock.
- R4: A frame whose stop bit is 0 makes `frameErr` pulse for one clock. It does not change `rxByte` and is not counted.
- R5: `secCount` counts good bytes received in monitor mode. It saturates at 8. Bytes sent after the eighth do not change `secCount` or `rxByte` and do not pulse `rxValid`.
- R6: After the eighth good byte, `txOe` is 1 and `txOut` is 0 for exactly 160 ticks, which is a break of 10 zero bits.
- R7: `txOe` is 0 at all other times, and `txOut` is 1 whenever `txOe` is 0.
- R8: `ready` goes to 1 when the break ends and stays 1 until reset.
- R9: `clkSelInt` is 0 after reset. It becomes 1 when monitor mode is latched and `hvDetect` is 0. Once set, it stays 1 until reset, even if `hvDetect` returns to 1.
- R10: Without monitor entry, serial input is ignored: `secCount` stays 0, and `txOe`, `ready` and `clkSelInt` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Internal reset, active low, asynchronous assert |
| hvDetect | input | 1 | High voltage present on the interrupt pin |
| modeSel | input | 2 | Mode-select inputs sampled at reset release |
| bitTick16 | input | 1 | One-clock pulse at 16 times the bit rate |
| rxIn | input | 1 | Serial line as seen by the receiver, idle high |
| txOut | output | 1 | Serial line drive value |
| txOe | output | 1 | Serial line output enable |
| clkSelInt | output | 1 | 1 selects the internal oscillator |
| monMode | output | 1 | Latched monitor mode |
| ready | output | 1 | Break sent, ready for a command |
| rxByte | output | 8 | Last good security byte |
| rxValid | output | 1 | One-clock pulse on a good byte |
| frameErr | output | 1 | One-clock pulse on a zero stop bit |
| secCount | output | 4 | Good security bytes received, saturating at 8 |

## Verification
The assertions assume that `bitTick16` is a single-clock pulse, spaced several clocks apart. They also assume that the host keeps quiet on `rxIn` while the block drives the break, so the only traffic is host-to-block frames. The stimulus makes the tick in the bench as one pulse every four clocks. It sends each frame bit for exactly 16 ticks and changes `rxIn`, `hvDetect` and `modeSel` only on falling clock edges. The host sends nothing between the eighth byte and the end of the break.

// File: rtl/mon_pkg.sv
package mon_pkg;

  typedef struct packed {
    logic rxEnable;
    logic txStart;
  } monStrobe_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_t;

  typedef enum logic [1:0] {
    SEQ_OFF,
    SEQ_INTAKE,
    SEQ_BREAK,
    SEQ_READY
  } seqState_t;

endpackage

// File: rtl/mon_datapath.sv
module mon_datapath
  import mon_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8,
  parameter int BREAK_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 rxIn,
  input  monStrobe_t           ctrl,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 rxValid,
  output logic                 frameErr,
  output logic                 txOut,
  output logic                 txOe,
  output logic                 breakDone
);

  localparam int SW = $clog2(OVERSAMPLE);
  localparam int BW = $clog2(DATA_BITS);
  localparam int TW = $clog2(OVERSAMPLE * BREAK_BITS);
  localparam logic [SW-1:0] MID_S   = SW'(OVERSAMPLE / 2 - 1);
  localparam logic [SW-1:0] LAST_S  = SW'(OVERSAMPLE - 1);
  localparam logic [BW-1:0] LAST_B  = BW'(DATA_BITS - 1);
  localparam logic [TW-1:0] LAST_T  = TW'(OVERSAMPLE * BREAK_BITS - 1);

  rxState_t             rxSt;
  logic [SW-1:0]        sCnt;
  logic [BW-1:0]        bitIdx;
  logic [DATA_BITS-1:0] shReg;
  logic                 txBusy;
  logic [TW-1:0]        tCnt;

  // receiver
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSt     <= RX_IDLE;
      sCnt     <= '0;
      bitIdx   <= '0;
      shReg    <= '0;
      rxByte   <= '0;
      rxValid  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      rxValid  <= 1'b0;
      frameErr <= 1'b0;
      if (!ctrl.rxEnable) begin
        rxSt <= RX_IDLE;
      end else if (tick) begin
        case (rxSt)
          RX_IDLE: begin
            if (!rxIn) begin
              rxSt <= RX_START;
              sCnt <= '0;
            end
          end
          RX_START: begin
            if (sCnt == MID_S) begin
              sCnt   <= '0;
              bitIdx <= '0;
              rxSt   <= rxIn ? RX_IDLE : RX_DATA;
            end else begin
              sCnt <= sCnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (sCnt == LAST_S) begin
              sCnt  <= '0;
              shReg <= {rxIn, shReg[DATA_BITS-1:1]};
              if (bitIdx == LAST_B) rxSt <= RX_STOP;
              else bitIdx <= bitIdx + 1'b1;
            end else begin
              sCnt <= sCnt + 1'b1;
            end
          end
          default: begin
            if (sCnt == LAST_S) begin
              sCnt <= '0;
              rxSt <= RX_IDLE;
              if (rxIn) begin
                rxByte  <= shReg;
                rxValid <= 1'b1;
              end else begin
                frameErr <= 1'b1;
              end
            end else begin
              sCnt <= sCnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // break transmitter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy    <= 1'b0;
      tCnt      <= '0;
      breakDone <= 1'b0;
    end else begin
      breakDone <= 1'b0;
      if (ctrl.txStart) begin
        txBusy <= 1'b1;
        tCnt   <= '0;
      end else if (txBusy && tick) begin
        if (tCnt == LAST_T) begin
          txBusy    <= 1'b0;
          breakDone <= 1'b1;
        end else begin
          tCnt <= tCnt + 1'b1;
        end
      end
    end
  end

  assign txOe  = txBusy;
  assign txOut = ~txBusy;

endmodule

// File: rtl/mon_control.sv
module mon_control
  import mon_pkg::*;
#(
  parameter int                  SEC_BYTES  = 8,
  parameter int                  MODE_W     = 2,
  parameter logic [MODE_W-1:0]   MODE_ENTRY = 2'b01,
  localparam int                 CW         = $clog2(SEC_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hvDetect,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              rxValid,
  input  logic              breakDone,
  output monStrobe_t        ctrl,
  output logic              monMode,
  output logic              clkSelInt,
  output logic              ready,
  output logic [CW-1:0]     secCount
);

  localparam logic [CW-1:0] LAST_C = CW'(SEC_BYTES - 1);

  seqState_t seqSt;
  logic      sampled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampled   <= 1'b0;
      monMode   <= 1'b0;
      clkSelInt <= 1'b0;
      seqSt     <= SEQ_OFF;
      secCount  <= '0;
    end else begin
      if (!sampled) begin
        sampled <= 1'b1;
        monMode <= hvDetect && (modeSel == MODE_ENTRY);
        if (hvDetect && (modeSel == MODE_ENTRY)) seqSt <= SEQ_INTAKE;
      end
      if (sampled && monMode && !hvDetect) clkSelInt <= 1'b1;
      case (seqSt)
        SEQ_INTAKE: begin
          if (rxValid) begin
            secCount <= secCount + 1'b1;
            if (secCount == LAST_C) seqSt <= SEQ_BREAK;
          end
        end
        SEQ_BREAK: begin
          if (breakDone) seqSt <= SEQ_READY;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl.rxEnable = (seqSt == SEQ_INTAKE);
    ctrl.txStart  = (seqSt == SEQ_INTAKE) && rxValid && (secCount == LAST_C);
  end

  assign ready = (seqSt == SEQ_READY);

endmodule

// File: rtl/mon_entry_seq.sv
module mon_entry_seq
  import mon_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8,
  parameter int BREAK_BITS = 10,
  parameter int SEC_BYTES  = 8,
  localparam int CW        = $clog2(SEC_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hvDetect,
  input  logic [1:0]           modeSel,
  input  logic                 bitTick16,
  input  logic                 rxIn,
  output logic                 txOut,
  output logic                 txOe,
  output logic                 clkSelInt,
  output logic                 monMode,
  output logic                 ready,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 rxValid,
  output logic                 frameErr,
  output logic [CW-1:0]        secCount
);

  monStrobe_t ctrl;
  logic       breakDone;

  mon_control #(
    .SEC_BYTES (SEC_BYTES),
    .MODE_W    (2),
    .MODE_ENTRY(2'b01)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hvDetect (hvDetect),
    .modeSel  (modeSel),
    .rxValid  (rxValid),
    .breakDone(breakDone),
    .ctrl     (ctrl),
    .monMode  (monMode),
    .clkSelInt(clkSelInt),
    .ready    (ready),
    .secCount (secCount)
  );

  mon_datapath #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_BITS (DATA_BITS),
    .BREAK_BITS(BREAK_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (bitTick16),
    .rxIn     (rxIn),
    .ctrl     (ctrl),
    .rxByte   (rxByte),
    .rxValid  (rxValid),
    .frameErr (frameErr),
    .txOut    (txOut),
    .txOe     (txOe),
    .breakDone(breakDone)
  );

endmodule

// File: rtl/mon_entry_seq_chk.sv
module mon_entry_seq_chk #(
  parameter int DATA_BITS = 8,
  parameter int CW        = 4,
  parameter int SEC_BYTES = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 hvDetect,
  input logic                 txOut,
  input logic                 txOe,
  input logic                 clkSelInt,
  input logic                 monMode,
  input logic                 ready,
  input logic                 rxValid,
  input logic                 frameErr,
  input logic [CW-1:0]        secCount
);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cyc <= '0;
    else if (cyc != 2'd2) cyc <= cyc + 1'b1;
  end

  // R2
  a_r2_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd2) |-> $stable(monMode));

  // R7
  a_r7_line_low_when_driven: assert property (@(posedge clk) disable iff (!rstN)
    txOe |-> !txOut);

  a_r7_line_high_when_released: assert property (@(posedge clk) disable iff (!rstN)
    !txOe |-> txOut);

  // R8
  a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  a_r8_ready_line_free: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !txOe);

  // R9
  a_r9_clksel_sticky: assert property (@(posedge clk) disable iff (!rstN)
    clkSelInt |=> clkSelInt);

  a_r9_clksel_needs_mode: assert property (@(posedge clk) disable iff (!rstN)
    clkSelInt |-> monMode);

  // R5
  a_r5_count_saturates: assert property (@(posedge clk) disable iff (!rstN)
    secCount <= CW'(SEC_BYTES));

  // R4
  a_r4_err_not_valid: assert property (@(posedge clk) disable iff (!rstN)
    !(frameErr && rxValid));

  // R10
  a_r10_quiet_without_entry: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd2 && !monMode) |-> (!txOe && !ready && secCount == '0 && !clkSelInt));

endmodule

bind mon_entry_seq mon_entry_seq_chk #(
  .DATA_BITS(DATA_BITS),
  .CW       (CW),
  .SEC_BYTES(SEC_BYTES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hvDetect (hvDetect),
  .txOut    (txOut),
  .txOe     (txOe),
  .clkSelInt(clkSelInt),
  .monMode  (monMode),
  .ready    (ready),
  .rxValid  (rxValid),
  .frameErr (frameErr),
  .secCount (secCount)
);

// File: tb/mon_entry_seq_test.sv
module mon_entry_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  localparam int NVEC       = 10;

  // {data, stopBit, expCount, expErrTotal}
  localparam logic [16:0] VEC [NVEC] = '{
    {8'hA5, 1'b1, 4'd1, 4'd0},
    {8'h3C, 1'b1, 4'd2, 4'd0},
    {8'hFF, 1'b0, 4'd2, 4'd1},
    {8'h00, 1'b1, 4'd3, 4'd1},
    {8'h81, 1'b1, 4'd4, 4'd1},
    {8'h7E, 1'b1, 4'd5, 4'd1},
    {8'h55, 1'b0, 4'd5, 4'd2},
    {8'h12, 1'b1, 4'd6, 4'd2},
    {8'hC3, 1'b1, 4'd7, 4'd2},
    {8'h9A, 1'b1, 4'd8, 4'd2}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hvDetect = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       bitTick16 = 1'b0;
  logic       rxIn = 1'b1;
  logic       txOut, txOe, clkSelInt, monMode, ready, rxValid, frameErr;
  logic [7:0] rxByte;
  logic [3:0] secCount;

  int checks = 0;
  int failures = 0;
  int tickPhase = 0;
  int brkTicks = 0;
  int oeClocks = 0;
  int lineErrs = 0;
  int validCnt = 0;
  int errCnt = 0;
  logic [7:0] lastGood;

  mon_entry_seq uut (
    .clk(clk), .rstN(rstN), .hvDetect(hvDetect), .modeSel(modeSel),
    .bitTick16(bitTick16), .rxIn(rxIn), .txOut(txOut), .txOe(txOe),
    .clkSelInt(clkSelInt), .monMode(monMode), .ready(ready),
    .rxByte(rxByte), .rxValid(rxValid), .frameErr(frameErr),
    .secCount(secCount)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // tick generation and line monitoring at the falling edge
  always @(negedge clk) begin
    if (rxValid) validCnt++;
    if (frameErr) errCnt++;
    if (txOe) oeClocks++;
    if (txOe && txOut) lineErrs++;
    if (!txOe && !txOut) lineErrs++;
    tickPhase = (tickPhase + 1) % TICK_DIV;
    if (tickPhase == 0 && txOe) brkTicks++;
    bitTick16 <= (tickPhase == 0);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic hv, input logic [1:0] sel);
    @(negedge clk);
    rstN = 1'b0;
    hvDetect = hv;
    modeSel = sel;
    rxIn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    rxIn = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] d, input logic stopBit);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
    sendBit(stopBit);
    sendBit(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 / R10: no high voltage, no entry
    doReset(1'b0, 2'b01);
    check("R1 reset outputs monMode", monMode, 0);
    check("R1 reset rxByte", rxByte, 0);
    oeClocks = 0;
    sendByte(8'h5A, 1'b1);
    check("R10 count without entry", secCount, 0);
    check("R10 no valid without entry", validCnt, 0);
    check("R10 no line drive", oeClocks, 0);
    check("R10 ready low", ready, 0);
    check("R10 clkSelInt low", clkSelInt, 0);

    // R1: wrong mode select
    doReset(1'b1, 2'b00);
    check("R1 wrong modeSel", monMode, 0);

    // R1 / R2 / R9: proper entry
    doReset(1'b1, 2'b01);
    check("R1 entry latched", monMode, 1);
    check("R9 clkSel while hv high", clkSelInt, 0);
    modeSel = 2'b10;
    repeat (2) @(negedge clk);
    check("R2 modeSel change ignored", monMode, 1);
    hvDetect = 1'b0;
    @(negedge clk);
    check("R9 clkSel after hv drop", clkSelInt, 1);
    check("R2 hv drop ignored", monMode, 1);
    hvDetect = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 clkSel sticky", clkSelInt, 1);
    hvDetect = 1'b0;

    // R3 / R4 / R5 vector walk
    validCnt = 0;
    errCnt = 0;
    lastGood = 8'h00;
    brkTicks = 0;
    oeClocks = 0;
    lineErrs = 0;
    for (int v = 0; v < NVEC; v++) begin
      if (v == NVEC - 1) begin
        rxIn = 1'b0;
        sendBit(1'b0);
        for (int i = 0; i < 8; i++) sendBit(VEC[v][16 - 7 + i]);
        sendBit(VEC[v][8]);
      end else begin
        check("R6 no break before eighth byte", oeClocks, 0);
        sendByte(VEC[v][16:9], VEC[v][8]);
      end
      if (VEC[v][8]) lastGood = VEC[v][16:9];
      if (v != NVEC - 1) begin
        check("R5 count", secCount, int'(VEC[v][7:4]));
        check("R4 frame errors", errCnt, int'(VEC[v][3:0]));
        check("R3 rxByte", rxByte, lastGood);
      end
    end
    rxIn = 1'b1;
    check("R3 valid pulses", validCnt, 8);

    // R6 / R7 / R8: break
    repeat (16 * 10 * TICK_DIV + 20) @(negedge clk);
    check("R5 count at eight", secCount, 8);
    check("R3 last byte", rxByte, 8'h9A);
    check("R6 break ticks", brkTicks, 160);
    check("R7 line value vs enable", lineErrs, 0);
    check("R7 enable released", txOe, 0);
    check("R8 ready after break", ready, 1);

    // R5: extra byte ignored
    sendByte(8'h44, 1'b1);
    check("R5 saturated count", secCount, 8);
    check("R5 extra byte not loaded", rxByte, 8'h9A);
    check("R5 no extra valid", validCnt, 8);
    check("R8 ready held", ready, 1);
    check("R7 no second break", brkTicks, 160);

    // reset clears
    doReset(1'b0, 2'b00);
    check("R8 ready cleared by reset", ready, 0);
    check("R9 clkSel cleared by reset", clkSelInt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule